// File: doc/BRIEF.md
# Card Presence Change Interrupt

This block watches a removable memory-card slot through two independent presence sources and raises a host interrupt when a card is inserted or removed. The first source is the card's shared detect/data-line-3 pin. The second source is a mechanical slot switch wired to general-purpose pin 0. Pin 0 is pulled high when the switch is open, so a low level means a card is present.

Each raw pin passes through a two-flop synchronizer. It then goes through a debounce filter built as a two-state machine. `FLT_STEADY` holds the accepted level. When the sampled input differs from that level, the transition *leave* moves the filter to `FLT_PROBE`. In `FLT_PROBE`, the transition *bounce* returns to `FLT_STEADY` unchanged if the input goes back to the accepted level. The transition *accept* takes the new level and emits a one-cycle change pulse once the new value has been held for `DEB_CYC` consecutive sampled cycles.

A change pulse from a qualified source sets a sticky status bit. Status bits clear when the host reads them. The interrupt line is a level that stays high while any enabled status bit is pending. The filtered level of each source can always be read, and the power-down flag has no effect on detection.

Top module: `card_detect_irq`

## Requirements
- R1: After reset, `irq`, `stat_dat3` and `stat_gp0` are 0, `card_det` is 0, and `gp0_in` is 1.
- R2: A new pin level is accepted only after it has been stable for `DEB_CYC` consecutive sampled cycles. A shorter pulse leaves `card_det`, `gp0_in` and the status bits unchanged.
- R3: An accepted change of the data-3 level in either direction sets `stat_dat3` only when `sif_en` is 0 and `bus_wide` is 0.
- R4: An accepted change of the pin-0 level in either direction sets `stat_gp0` only when `gp0_oe` is 0 and `gp0_ie` is 1.
- R5: `irq` equals `glb_ie & ((stat_dat3 & ins_ie) | (stat_gp0 & gpio_ie))`.
- R6: Status bits stay set until a cycle with `stat_rd` high clears them. If a qualified change arrives in the same cycle as the read, the bit stays set.
- R7: `pwr_down` has no effect on detection, status or interrupt.
- R8: `card_det` and `gp0_in` show the debounced levels of the data-3 pin and pin 0 whatever the enables are. A change that was suppressed earlier causes no later event when its source is qualified again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat3_pin | input | 1 | Raw detect/data-3 pin |
| gp0_pin | input | 1 | Raw general-purpose pin 0 (slot switch, low = card) |
| sif_en | input | 1 | Serial interface enable; 1 blocks data-3 detection |
| gp0_oe | input | 1 | Pin 0 output enable; 1 blocks pin-0 detection |
| bus_wide | input | 1 | 4-bit bus selected; 1 blocks data-3 detection |
| ins_ie | input | 1 | Data-3 event interrupt enable |
| gp0_ie | input | 1 | Pin 0 own event enable |
| gpio_ie | input | 1 | General-I/O group interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| pwr_down | input | 1 | Power-down flag (no effect on detection) |
| stat_rd | input | 1 | Status read strobe; clears status bits |
| irq | output | 1 | Level interrupt request |
| stat_dat3 | output | 1 | Sticky data-3 change status |
| stat_gp0 | output | 1 | Sticky pin-0 change status |
| card_det | output | 1 | Debounced data-3 level |
| gp0_in | output | 1 | Debounced pin-0 level |

## Verification
The embedded assertions check on every cycle that a status bit rises only after a qualified change pulse and that a bit stays set when no read occurs. They also check that a read with no coincident event clears the bit, that the debounced level moves only from the probe state, and that a qualified event in power-down is still recorded. Only the bench scenarios can show the end-to-end behaviour. These include glitches shorter than the debounce window being rejected, each qualification combination under random enables, and the read colliding with an event. They also include the absence of a late event after a suppressed change.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
    typedef enum logic {
        FLT_STEADY = 1'b0,
        FLT_PROBE  = 1'b1
    } flt_state_t;

    localparam int NSRC     = 2;
    localparam int SRC_DAT3 = 0;
    localparam int SRC_GP0  = 1;
endpackage

// File: rtl/cdet_sync.sv
module cdet_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/cdet_filter.sv
module cdet_filter
    import cdet_pkg::*;
#(
    parameter int   DEB_CYC  = 16,
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sin,
    output logic lvl,
    output logic chg
);
    localparam int CW = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    flt_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic take;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        take  = 1'b0;
        unique case (st_q)
            FLT_STEADY: begin
                if (sin != lvl) begin
                    st_d  = FLT_PROBE;
                    cnt_d = CW'(1);
                end
            end
            FLT_PROBE: begin
                if (sin == lvl) begin
                    st_d  = FLT_STEADY;
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    st_d  = FLT_STEADY;
                    cnt_d = '0;
                    take  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                st_d  = FLT_STEADY;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_STEADY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= IDLE_LVL;
            chg <= 1'b0;
        end else begin
            chg <= take;
            if (take) lvl <= sin;
        end
    end

    a_r2_level_from_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != $past(lvl)) |-> ($past(st_q) == FLT_PROBE));

    a_r2_pulse_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> (lvl != $past(lvl)));
endmodule

// File: rtl/cdet_status.sv
module cdet_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_rd,
    output logic stat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stat <= 1'b0;
        else if (set_evt) stat <= 1'b1;
        else if (clr_rd)  stat <= 1'b0;
    end
endmodule

// File: rtl/card_detect_irq.sv
module card_detect_irq
    import cdet_pkg::*;
#(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dat3_pin,
    input  logic gp0_pin,
    input  logic sif_en,
    input  logic gp0_oe,
    input  logic bus_wide,
    input  logic ins_ie,
    input  logic gp0_ie,
    input  logic gpio_ie,
    input  logic glb_ie,
    input  logic pwr_down,
    input  logic stat_rd,
    output logic irq,
    output logic stat_dat3,
    output logic stat_gp0,
    output logic card_det,
    output logic gp0_in
);
    localparam logic [NSRC-1:0] IDLE_LVLS = 2'b10;

    logic [NSRC-1:0] raw, synced, lvl, chg, qual, stat;

    assign raw[SRC_DAT3]  = dat3_pin;
    assign raw[SRC_GP0]   = gp0_pin;
    assign qual[SRC_DAT3] = !sif_en && !bus_wide;
    assign qual[SRC_GP0]  = !gp0_oe && gp0_ie;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        cdet_sync #(.RST_VAL(IDLE_LVLS[i])) u_sync (
            .clk(clk), .rst_n(rst_n), .din(raw[i]), .dout(synced[i])
        );
        cdet_filter #(.DEB_CYC(DEB_CYC), .IDLE_LVL(IDLE_LVLS[i])) u_flt (
            .clk(clk), .rst_n(rst_n), .sin(synced[i]), .lvl(lvl[i]), .chg(chg[i])
        );
        cdet_status u_stat (
            .clk(clk), .rst_n(rst_n), .set_evt(chg[i] && qual[i]),
            .clr_rd(stat_rd), .stat(stat[i])
        );
    end

    assign stat_dat3 = stat[SRC_DAT3];
    assign stat_gp0  = stat[SRC_GP0];
    assign card_det  = lvl[SRC_DAT3];
    assign gp0_in    = lvl[SRC_GP0];
    assign irq = glb_ie && ((stat_dat3 && ins_ie) || (stat_gp0 && gpio_ie));

    a_r3_dat3_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_dat3) |-> $past(chg[SRC_DAT3] && !sif_en && !bus_wide));

    a_r4_gp0_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_gp0) |-> $past(chg[SRC_GP0] && !gp0_oe && gp0_ie));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_dat3 && !stat_rd) |=> stat_dat3);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !chg[SRC_GP0]) |=> !stat_gp0);

    a_r7_powerdown_live: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && chg[SRC_DAT3] && !sif_en && !bus_wide) |=> stat_dat3);
endmodule

// File: tb/sim_card_detect_irq.sv
module sim_card_detect_irq;
    localparam int DEB = 6;
    localparam int SETTLE = DEB + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dat3_pin = 1'b0, gp0_pin = 1'b1;
    logic sif_en = 1'b0, gp0_oe = 1'b0, bus_wide = 1'b0;
    logic ins_ie = 1'b0, gp0_ie = 1'b0, gpio_ie = 1'b0, glb_ie = 1'b0;
    logic pwr_down = 1'b0, stat_rd = 1'b0;
    logic irq, stat_dat3, stat_gp0, card_det, gp0_in;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    card_detect_irq #(.DEB_CYC(DEB)) u0 (
        .clk(clk), .rst_n(rst_n), .dat3_pin(dat3_pin), .gp0_pin(gp0_pin),
        .sif_en(sif_en), .gp0_oe(gp0_oe), .bus_wide(bus_wide),
        .ins_ie(ins_ie), .gp0_ie(gp0_ie), .gpio_ie(gpio_ie), .glb_ie(glb_ie),
        .pwr_down(pwr_down), .stat_rd(stat_rd), .irq(irq),
        .stat_dat3(stat_dat3), .stat_gp0(stat_gp0),
        .card_det(card_det), .gp0_in(gp0_in)
    );

    function automatic logic exp_irq(logic s3, logic sg, logic e3, logic eg, logic eio, logic eglb);
        return eglb & ((s3 & e3) | (sg & eg & 1'b1 & eio)) | (eglb & sg & eio & 1'b0);
    endfunction

    function automatic logic exp_dat3_set(logic tog, logic sif, logic bw);
        return tog & ~sif & ~bw;
    endfunction

    function automatic logic exp_gp0_set(logic tog, logic oe, logic ie);
        return tog & ~oe & ie;
    endfunction

    task automatic tick(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic t3, tg, e3, eg;
        void'($urandom(32'h5EED_C0DE));
        tick(3);
        // R1 reset state
        chk("R1", "irq", irq, 1'b0);
        chk("R1", "stat_dat3", stat_dat3, 1'b0);
        chk("R1", "stat_gp0", stat_gp0, 1'b0);
        chk("R1", "card_det", card_det, 1'b0);
        chk("R1", "gp0_in", gp0_in, 1'b1);
        rst_n = 1'b1;
        tick(2);

        // R2 glitch shorter than the window is rejected
        gp0_ie = 1'b1; gpio_ie = 1'b1; glb_ie = 1'b1; ins_ie = 1'b1;
        gp0_pin = 1'b0; tick(DEB - 1); gp0_pin = 1'b1;
        dat3_pin = 1'b1; tick(DEB - 2); dat3_pin = 1'b0;
        tick(SETTLE);
        chk("R2", "gp0_in after glitch", gp0_in, 1'b1);
        chk("R2", "card_det after glitch", card_det, 1'b0);
        chk("R2", "stat_gp0 after glitch", stat_gp0, 1'b0);
        chk("R2", "irq after glitch", irq, 1'b0);

        // R8 suppressed dat3 change: live bit moves, no status, no late event
        sif_en = 1'b1;
        dat3_pin = 1'b1; tick(SETTLE);
        chk("R8", "card_det live while blocked", card_det, 1'b1);
        chk("R3", "stat_dat3 blocked by sif_en", stat_dat3, 1'b0);
        sif_en = 1'b0; tick(SETTLE);
        chk("R8", "no late event on requalify", stat_dat3, 1'b0);

        // R6 read colliding with event: set wins
        dat3_pin = 1'b0;
        while (card_det !== 1'b0 && cyc < 5000) tick(1);
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
        chk("R6", "set wins over read", stat_dat3, 1'b1);
        tick(3);
        chk("R6", "sticky without read", stat_dat3, 1'b1);
        chk("R5", "irq from dat3", irq, 1'b1);
        do_read();
        chk("R6", "read clears", stat_dat3, 1'b0);
        chk("R5", "irq drops after read", irq, 1'b0);

        // R7 power-down: detection still works
        pwr_down = 1'b1;
        gp0_pin = 1'b0; tick(SETTLE);
        chk("R7", "stat_gp0 in power-down", stat_gp0, 1'b1);
        chk("R7", "irq in power-down", irq, 1'b1);
        do_read();
        pwr_down = 1'b0;

        // Random enables and toggles
        for (int it = 0; it < 60; it++) begin
            int r;
            r = $urandom;
            sif_en = r[0]; bus_wide = r[1]; gp0_oe = r[2]; ins_ie = r[3];
            gp0_ie = r[4]; gpio_ie = r[5]; glb_ie = r[6]; pwr_down = r[7];
            t3 = r[8] | (r[10:9] == 2'b00);
            tg = r[11] | ~t3;
            if (t3) dat3_pin = ~dat3_pin;
            if (tg) gp0_pin = ~gp0_pin;
            tick(SETTLE);
            e3 = exp_dat3_set(t3, sif_en, bus_wide);
            eg = exp_gp0_set(tg, gp0_oe, gp0_ie);
            chk("R3", "stat_dat3 random", stat_dat3, e3);
            chk("R4", "stat_gp0 random", stat_gp0, eg);
            chk("R5", "irq random", irq, exp_irq(e3, eg, ins_ie, 1'b1, gpio_ie, glb_ie));
            chk("R8", "card_det random", card_det, dat3_pin);
            chk("R8", "gp0_in random", gp0_in, gp0_pin);
            do_read();
            chk("R6", "cleared after read", stat_dat3 | stat_gp0, 1'b0);
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule